// File: doc/BRIEF.md
# Two-Cell Capacitor Balancing State Selector

This block drives the switches of one converter limb built from a fundamental-frequency main H-bridge fed through two series H-bridge cells on its dc side. At each sampling strobe it takes four inputs: the level to be synthesized, the polarity chosen for the main bridge at the zero level, the sign of the limb dc current, and the two digitized cell capacitor voltages. From these it registers a new gate pattern for both cells and for the main bridge. It picks which cell to insert, or which cell to charge while the other is discharged, so that both capacitor voltages stay near their nominal value, which is half the dc link voltage.

At the full levels both cells are normally bypassed. Only when a capacitor drifts out of a tolerance band around nominal does the block use the bipolar ability of the cells: one cell is inserted forward and the other reversed, so that one capacitor charges while the other discharges. At the half levels exactly one cell is inserted, chosen by voltage and current sign. At the zero level both cells are inserted. The lower device of each leg is always the complement of the upper one, and all gates are held low from reset until the first strobe.

Top module: `cell_balance_sel`

## Requirements
- R1: While reset is held, and after reset until the first clock edge with `sample_i` high, all twelve gate outputs are 0.
- R2: Gate outputs change only on the clock edge where `sample_i` is 1, and show the new pattern from that edge on. With `sample_i` at 0 they hold their value whatever the other inputs do.
- R3: `level_i` is a signed 3-bit code: 0 is the zero level, +1/−1 the positive/negative half levels, +2/−2 the full levels. For a positive code `main_gate_o` is 4'b1001 and for a negative code it is 4'b0110. For code 0 it is 4'b1001 when `zero_pol_i` is 1 and 4'b0110 otherwise. Gate bit order for every bridge is [0] leg A upper, [1] leg A lower, [2] leg B upper, [3] leg B lower.
- R4: At the zero level both cell gate vectors are 4'b0110, which inserts both cells.
- R5: At a half level exactly one cell is inserted (4'b0110) and the other bypassed (4'b0101). With `idc_neg_i`=0 (current charges an inserted cell) the cell with the lower voltage is inserted. With `idc_neg_i`=1 the cell with the higher voltage is inserted.
- R6: At a half level with equal voltages the previously inserted half-level cell is inserted again. After reset that cell is cell 1.
- R7: At a full level with both voltages within the band, both cells are bypassed (4'b0101).
- R8: At a full level with a voltage out of band, the block drives one of two bipolar states. State A is cell1 4'b1001 with cell2 4'b0110; it discharges cell 1 and charges cell 2 when `idc_neg_i`=0, and does the reverse when `idc_neg_i`=1. State B is cell1 4'b0110 with cell2 4'b1001. The chosen state drives the target capacitor toward nominal.
- R9: A voltage is out of band when |v − VNOM| > VNOM·BAND_PCT/100, which is 204 codes around 2048 by default. The target is the capacitor with the larger deviation, and cell 1 wins a tie.
- R10: In every bridge the two gates of a leg are never both 1.
- R11: Codes +3 are treated as +2. Codes −3 and −4 are treated as −2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | Sampling strobe, one cycle per period |
| level_i | input | 3 | Signed level code |
| zero_pol_i | input | 1 | Main bridge polarity at zero level (1 = positive pair) |
| idc_neg_i | input | 1 | Limb dc current is negative |
| vc1_i | input | VW | Cell 1 capacitor voltage code |
| vc2_i | input | VW | Cell 2 capacitor voltage code |
| cell1_gate_o | output | 4 | Cell 1 gates |
| cell2_gate_o | output | 4 | Cell 2 gates |
| main_gate_o | output | 4 | Main bridge gates |

## Verification
The only internal state besides the output registers is the remembered half-level cell. If it is wrong, the fault shows up only at the next half-level strobe with equal voltages, when the other cell's vector reads 4'b0110. The bench therefore forces such ties both after a run and straight after reset. A wrong band or target decision shows in the cycle after the strobe as a bypass pattern where a bipolar pattern was due, or as the swapped bipolar state. Vectors placed exactly on and one code past each band edge separate off-by-one comparisons.

// File: rtl/cbal_pkg.sv
package cbal_pkg;

  // upper-switch states of one H-bridge; lower switches are their complements
  typedef struct packed {
    logic up_b;
    logic up_a;
  } cell_sw_t;

  localparam cell_sw_t SW_BYPASS  = '{up_b: 1'b1, up_a: 1'b1};
  localparam cell_sw_t SW_INSERT  = '{up_b: 1'b1, up_a: 1'b0};
  localparam cell_sw_t SW_REVERSE = '{up_b: 1'b0, up_a: 1'b1};

  typedef enum logic [1:0] {
    LVL_ZERO,
    LVL_HALF,
    LVL_FULL
  } lvl_mag_e;

  function automatic lvl_mag_e lvl_decode(logic signed [2:0] code);
    case (code)
      3'sd0:         return LVL_ZERO;
      3'sd1, -3'sd1: return LVL_HALF;
      default:       return LVL_FULL;
    endcase
  endfunction

endpackage

// File: rtl/cbal_band.sv
module cbal_band #(
  parameter int VW   = 12,
  parameter int VNOM = 2048,
  parameter int BAND = 204
) (
  input  logic [VW-1:0] vc_i,
  output logic [VW+1:0] mag_o,
  output logic          over_o,
  output logic          out_o
);
  localparam int MW = VW + 2;

  logic [MW-1:0] diff;

  assign diff   = {2'b00, vc_i} - MW'(VNOM);
  assign over_o = ~diff[MW-1];
  assign mag_o  = diff[MW-1] ? (~diff + MW'(1)) : diff;
  assign out_o  = mag_o > MW'(BAND);

endmodule

// File: rtl/cbal_pick.sv
module cbal_pick
  import cbal_pkg::*;
#(
  parameter int VW = 12
) (
  input  lvl_mag_e      lvl_i,
  input  logic          idc_neg_i,
  input  logic [VW-1:0] vc1_i,
  input  logic [VW-1:0] vc2_i,
  input  logic [VW+1:0] mag1_i,
  input  logic [VW+1:0] mag2_i,
  input  logic [1:0]    over_i,
  input  logic [1:0]    out_i,
  input  logic          half_prev_i,
  output cell_sw_t      sw1_o,
  output cell_sw_t      sw2_o,
  output logic          half_sel_o
);
  logic tgt2, want_dis1, state_a, pick2;

  // target: larger deviation, cell 1 on tie
  assign tgt2      = mag2_i > mag1_i;
  assign want_dis1 = tgt2 ? ~over_i[1] : over_i[0];
  assign state_a   = want_dis1 ^ idc_neg_i;

  always_comb begin
    if (vc1_i == vc2_i)  pick2 = half_prev_i;
    else if (idc_neg_i)  pick2 = vc2_i > vc1_i;
    else                 pick2 = vc2_i < vc1_i;
  end

  always_comb begin
    sw1_o      = SW_BYPASS;
    sw2_o      = SW_BYPASS;
    half_sel_o = half_prev_i;
    unique case (lvl_i)
      LVL_ZERO: begin
        sw1_o = SW_INSERT;
        sw2_o = SW_INSERT;
      end
      LVL_HALF: begin
        half_sel_o = pick2;
        if (pick2) sw2_o = SW_INSERT;
        else       sw1_o = SW_INSERT;
      end
      default: begin
        if (|out_i) begin
          sw1_o = state_a ? SW_REVERSE : SW_INSERT;
          sw2_o = state_a ? SW_INSERT  : SW_REVERSE;
        end
      end
    endcase
  end

endmodule

// File: rtl/cbal_gate.sv
module cbal_gate
  import cbal_pkg::*;
(
  input  logic     en_i,
  input  cell_sw_t sw_i,
  output logic [3:0] gate_o
);
  assign gate_o = en_i ? {~sw_i.up_b, sw_i.up_b, ~sw_i.up_a, sw_i.up_a} : 4'b0000;
endmodule

// File: rtl/cell_balance_sel.sv
module cell_balance_sel
  import cbal_pkg::*;
#(
  parameter int VW       = 12,
  parameter int VNOM     = 2048,
  parameter int BAND_PCT = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic signed [2:0] level_i,
  input  logic              zero_pol_i,
  input  logic              idc_neg_i,
  input  logic [VW-1:0]     vc1_i,
  input  logic [VW-1:0]     vc2_i,
  output logic [3:0]        cell1_gate_o,
  output logic [3:0]        cell2_gate_o,
  output logic [3:0]        main_gate_o
);
  localparam int BAND   = VNOM * BAND_PCT / 100;
  localparam int NCELL  = 2;
  localparam int NBRDG  = NCELL + 1;
  localparam int MW     = VW + 2;

  logic [VW-1:0] vc   [NCELL];
  logic [MW-1:0] mag  [NCELL];
  logic [NCELL-1:0] over, outb;

  assign vc[0] = vc1_i;
  assign vc[1] = vc2_i;

  for (genvar c = 0; c < NCELL; c++) begin : g_band
    cbal_band #(.VW(VW), .VNOM(VNOM), .BAND(BAND)) u_band (
      .vc_i  (vc[c]),
      .mag_o (mag[c]),
      .over_o(over[c]),
      .out_o (outb[c])
    );
  end

  lvl_mag_e lvl;
  logic     main_pos;
  cell_sw_t main_d, sw1_d, sw2_d;
  logic     half_d, half_q, en_q;
  cell_sw_t sw_q [NBRDG];
  logic [3:0] gate [NBRDG];

  assign lvl      = lvl_decode(level_i);
  assign main_pos = (lvl == LVL_ZERO) ? zero_pol_i : ~level_i[2];
  assign main_d   = main_pos ? SW_REVERSE : SW_INSERT;

  cbal_pick #(.VW(VW)) u_pick (
    .lvl_i      (lvl),
    .idc_neg_i  (idc_neg_i),
    .vc1_i      (vc1_i),
    .vc2_i      (vc2_i),
    .mag1_i     (mag[0]),
    .mag2_i     (mag[1]),
    .over_i     (over),
    .out_i      (outb),
    .half_prev_i(half_q),
    .sw1_o      (sw1_d),
    .sw2_o      (sw2_d),
    .half_sel_o (half_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      half_q  <= 1'b0;
      sw_q[0] <= SW_BYPASS;
      sw_q[1] <= SW_BYPASS;
      sw_q[2] <= SW_BYPASS;
    end else if (sample_i) begin
      en_q    <= 1'b1;
      half_q  <= half_d;
      sw_q[0] <= sw1_d;
      sw_q[1] <= sw2_d;
      sw_q[2] <= main_d;
    end
  end

  for (genvar b = 0; b < NBRDG; b++) begin : g_gate
    cbal_gate u_gate (
      .en_i  (en_q),
      .sw_i  (sw_q[b]),
      .gate_o(gate[b])
    );
  end

  assign cell1_gate_o = gate[0];
  assign cell2_gate_o = gate[1];
  assign main_gate_o  = gate[2];

endmodule

// File: rtl/cell_balance_sel_chk.sv
module cell_balance_sel_chk #(
  parameter int VW       = 12,
  parameter int VNOM     = 2048,
  parameter int BAND_PCT = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sample_i,
  input logic signed [2:0] level_i,
  input logic              zero_pol_i,
  input logic              idc_neg_i,
  input logic [VW-1:0]     vc1_i,
  input logic [VW-1:0]     vc2_i,
  input logic [3:0]        cell1_gate_o,
  input logic [3:0]        cell2_gate_o,
  input logic [3:0]        main_gate_o
);
  localparam int BAND = VNOM * BAND_PCT / 100;
  localparam logic [VW-1:0] LO = VW'(VNOM - BAND);
  localparam logic [VW-1:0] HI = VW'(VNOM + BAND);

  logic full, both_in;
  assign full    = level_i inside {3'b010, 3'b011, 3'b100, 3'b101, 3'b110};
  assign both_in = (vc1_i >= LO) && (vc1_i <= HI) && (vc2_i >= LO) && (vc2_i <= HI);

  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |-> ({cell1_gate_o, cell2_gate_o, main_gate_o} == 12'd0)); // R1

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> $stable({cell1_gate_o, cell2_gate_o, main_gate_o})); // R2

  AST_MAIN_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && !level_i[2] && level_i != 3'b000) |=> main_gate_o == 4'b1001); // R3

  AST_MAIN_NEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && level_i[2]) |=> main_gate_o == 4'b0110); // R3

  AST_ZERO_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && level_i == 3'b000) |=> (cell1_gate_o == 4'b0110 && cell2_gate_o == 4'b0110)); // R4

  AST_HALF_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && (level_i == 3'b001 || level_i == 3'b111)) |=>
      ((cell1_gate_o == 4'b0110 && cell2_gate_o == 4'b0101) ||
       (cell1_gate_o == 4'b0101 && cell2_gate_o == 4'b0110))); // R5

  AST_FULL_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && full && both_in) |=> (cell1_gate_o == 4'b0101 && cell2_gate_o == 4'b0101)); // R7

  AST_FULL_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && full && !both_in) |=>
      ((cell1_gate_o == 4'b1001 && cell2_gate_o == 4'b0110) ||
       (cell1_gate_o == 4'b0110 && cell2_gate_o == 4'b1001))); // R8

  AST_LEG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cell1_gate_o[0] & cell1_gate_o[1]) | (cell1_gate_o[2] & cell1_gate_o[3]) |
     (cell2_gate_o[0] & cell2_gate_o[1]) | (cell2_gate_o[2] & cell2_gate_o[3]) |
     (main_gate_o[0]  & main_gate_o[1])  | (main_gate_o[2]  & main_gate_o[3])) == 1'b0); // R10

endmodule

bind cell_balance_sel cell_balance_sel_chk #(
  .VW(VW), .VNOM(VNOM), .BAND_PCT(BAND_PCT)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sample_i    (sample_i),
  .level_i     (level_i),
  .zero_pol_i  (zero_pol_i),
  .idc_neg_i   (idc_neg_i),
  .vc1_i       (vc1_i),
  .vc2_i       (vc2_i),
  .cell1_gate_o(cell1_gate_o),
  .cell2_gate_o(cell2_gate_o),
  .main_gate_o (main_gate_o)
);

// File: tb/cell_balance_sel_test.sv
module cell_balance_sel_test;
  localparam int VW = 12;
  localparam int NV = 24;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              sample_i = 1'b0;
  logic signed [2:0] level_i = '0;
  logic              zero_pol_i = 1'b0;
  logic              idc_neg_i = 1'b0;
  logic [VW-1:0]     vc1_i = 12'd2048;
  logic [VW-1:0]     vc2_i = 12'd2048;
  logic [3:0]        c1, c2, mg;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  cell_balance_sel uut (
    .clk_i(clk), .rst_ni(rst_ni), .sample_i(sample_i), .level_i(level_i),
    .zero_pol_i(zero_pol_i), .idc_neg_i(idc_neg_i), .vc1_i(vc1_i), .vc2_i(vc2_i),
    .cell1_gate_o(c1), .cell2_gate_o(c2), .main_gate_o(mg)
  );

  // {level, zero_pol, idc_neg, vc1, vc2, exp cell1, exp cell2, exp main}
  localparam logic [40:0] VEC [NV] = '{
    {3'b010, 1'b0, 1'b0, 12'd2048, 12'd2048, 4'b0101, 4'b0101, 4'b1001}, // R7 R3
    {3'b110, 1'b0, 1'b0, 12'd2048, 12'd2048, 4'b0101, 4'b0101, 4'b0110}, // R7 R3
    {3'b010, 1'b0, 1'b0, 12'd2300, 12'd2048, 4'b1001, 4'b0110, 4'b1001}, // R8
    {3'b010, 1'b0, 1'b1, 12'd2300, 12'd2048, 4'b0110, 4'b1001, 4'b1001}, // R8
    {3'b010, 1'b0, 1'b0, 12'd1800, 12'd2048, 4'b0110, 4'b1001, 4'b1001}, // R8
    {3'b110, 1'b0, 1'b0, 12'd2048, 12'd2300, 4'b0110, 4'b1001, 4'b0110}, // R8
    {3'b110, 1'b0, 1'b1, 12'd2048, 12'd1800, 4'b0110, 4'b1001, 4'b0110}, // R8
    {3'b010, 1'b0, 1'b0, 12'd2300, 12'd1700, 4'b1001, 4'b0110, 4'b1001}, // R9 larger dev
    {3'b010, 1'b0, 1'b0, 12'd2300, 12'd2300, 4'b1001, 4'b0110, 4'b1001}, // R9 tie
    {3'b010, 1'b0, 1'b0, 12'd2252, 12'd2048, 4'b0101, 4'b0101, 4'b1001}, // R9 edge in
    {3'b010, 1'b0, 1'b0, 12'd2253, 12'd2048, 4'b1001, 4'b0110, 4'b1001}, // R9 edge out
    {3'b010, 1'b0, 1'b0, 12'd1844, 12'd2048, 4'b0101, 4'b0101, 4'b1001}, // R9 edge in
    {3'b010, 1'b0, 1'b0, 12'd1843, 12'd2048, 4'b0110, 4'b1001, 4'b1001}, // R9 edge out
    {3'b001, 1'b0, 1'b0, 12'd2000, 12'd2100, 4'b0110, 4'b0101, 4'b1001}, // R5
    {3'b001, 1'b0, 1'b1, 12'd2000, 12'd2100, 4'b0101, 4'b0110, 4'b1001}, // R5
    {3'b111, 1'b0, 1'b0, 12'd2100, 12'd2000, 4'b0101, 4'b0110, 4'b0110}, // R5
    {3'b111, 1'b0, 1'b0, 12'd2048, 12'd2048, 4'b0101, 4'b0110, 4'b0110}, // R6
    {3'b001, 1'b0, 1'b0, 12'd2000, 12'd2100, 4'b0110, 4'b0101, 4'b1001}, // R5
    {3'b001, 1'b0, 1'b1, 12'd2048, 12'd2048, 4'b0110, 4'b0101, 4'b1001}, // R6
    {3'b000, 1'b1, 1'b0, 12'd2048, 12'd2048, 4'b0110, 4'b0110, 4'b1001}, // R4 R3
    {3'b000, 1'b0, 1'b1, 12'd2048, 12'd2048, 4'b0110, 4'b0110, 4'b0110}, // R4 R3
    {3'b011, 1'b0, 1'b0, 12'd2048, 12'd2048, 4'b0101, 4'b0101, 4'b1001}, // R11
    {3'b100, 1'b0, 1'b0, 12'd2300, 12'd2048, 4'b1001, 4'b0110, 4'b0110}, // R11
    {3'b101, 1'b0, 1'b0, 12'd2048, 12'd2048, 4'b0101, 4'b0101, 4'b0110}  // R11
  };
  localparam int REQ [NV] = '{7, 7, 8, 8, 8, 8, 8, 9, 9, 9, 9, 9, 9,
                              5, 5, 5, 6, 5, 6, 4, 4, 11, 11, 11};

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got c1/c2/main %b_%b_%b expected %b_%b_%b", tag,
               act[11:8], act[7:4], act[3:0], exp[11:8], exp[7:4], exp[3:0]);
    end
  endtask

  task automatic strobe(input logic [2:0] lv, input logic zp, input logic ng,
                        input logic [VW-1:0] v1, input logic [VW-1:0] v2);
    level_i = lv; zero_pol_i = zp; idc_neg_i = ng; vc1_i = v1; vc2_i = v2;
    sample_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sample_i = 1'b0;
  endtask

  function automatic logic leg_clash(input logic [3:0] g);
    return (g[0] & g[1]) | (g[2] & g[3]);
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", {c1, c2, mg}, 12'd0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 before first strobe", {c1, c2, mg}, 12'd0);

    for (int i = 0; i < NV; i++) begin
      logic [40:0] v;
      v = VEC[i];
      strobe(v[40:38], v[37], v[36], v[35:24], v[23:12]);
      check($sformatf("R%0d vector %0d", REQ[i], i), {c1, c2, mg}, v[11:0]);
      checks++;
      if (leg_clash(c1) | leg_clash(c2) | leg_clash(mg)) begin
        fails++;
        $display("FAIL R10 vector %0d: got %b_%b_%b expected no leg with both gates high",
                 i, c1, c2, mg);
      end
    end

    // R2: inputs move without strobe, outputs hold
    level_i = 3'b001; idc_neg_i = 1'b1; vc1_i = 12'd1500; vc2_i = 12'd2600; zero_pol_i = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 hold without strobe", {c1, c2, mg}, {4'b0101, 4'b0101, 4'b0110});

    // R2: the strobed pattern appears one edge after the strobe
    strobe(3'b000, 1'b1, 1'b0, 12'd2048, 12'd2048);
    check("R2 update on strobe", {c1, c2, mg}, {4'b0110, 4'b0110, 4'b1001});

    // set remembered half cell to cell 2, then reset
    strobe(3'b001, 1'b0, 1'b1, 12'd2000, 12'd2100);
    check("R5 higher inserted", {c1, c2, mg}, {4'b0101, 4'b0110, 4'b1001});
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check("R1 async reset", {c1, c2, mg}, 12'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after reset", {c1, c2, mg}, 12'd0);

    // R6: tie right after reset picks cell 1
    strobe(3'b001, 1'b0, 1'b0, 12'd2048, 12'd2048);
    check("R6 tie after reset", {c1, c2, mg}, {4'b0110, 4'b0101, 4'b1001});

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule